// File: doc/BRIEF.md
# Center-Aligned PWM Channel with Dead-Time Insertion

This channel turns an external up/down time base into a center-aligned pulse. Another channel counts up from zero to a top value and back down. It presents that count on `tbase_val` and its direction on `tbase_up`. The channel holds an active duty threshold and an active dead-time length. When the count equals the duty threshold on the way up, one edge of the pulse is produced. When it equals the threshold on the way down, the other edge is produced. Because the two crossings sit symmetrically about the top of the count, the pulse is centered in the period.

Dead time delays one of the two edges by a number of clock cycles. A local counter, started by the threshold crossing, measures the delay. A two-bit mode input selects which edge is delayed. It also selects whether the one-cycle flag pulse marks only the falling edge of the output or both edges. Software writes new values into two shadow registers at any time. The active values take them only when the time base stands at zero, so a period is never built from a mix of old and new settings.

Top module: `ctr_pwm_dt`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `pwm_o` and `flag_o` are 0, and both active values and both shadow values are 0.
- R2: A one-cycle `a_wr`/`b_wr` strobe stores `a_data`/`b_data` in the duty/dead-time shadow. The active duty and dead-time values take their shadows on the clock edge that samples `tbase_val` equal to 0, and change at no other edge.
- R3: With `mode_sel[0]`=0 (trailing dead time), an up-crossing drives `pwm_o` to 1 on the next edge. An up-crossing is a cycle with `tbase_up`=1 and `tbase_val` equal to the active duty value.
- R4: With `mode_sel[0]`=0, a down-crossing starts the dead-time count, and `pwm_o` falls D edges after the edge that samples the crossing. A down-crossing has `tbase_up`=0 and the count equal to the active duty value. D is the active dead-time value; with D=0, `pwm_o` falls on that same edge.
- R5: With `mode_sel[0]`=1 (leading dead time), an up-crossing starts the dead-time count, and `pwm_o` rises D edges after the edge that samples the crossing.
- R6: With `mode_sel[0]`=1, a down-crossing drives `pwm_o` to 0 on the next edge.
- R7: An undelayed edge cancels a pending dead-time count. In leading mode, a dead time that reaches the down-crossing suppresses the pulse for that period.
- R8: `flag_o` is high for exactly the cycles in which `pwm_o` has just fallen, in every mode.
- R9: `flag_o` is also high for the cycles in which `pwm_o` has just risen, but only when `mode_sel[1]`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbase_val | input | W | External up/down time-base count |
| tbase_up | input | 1 | 1 while the time base counts up |
| mode_sel | input | 2 | Bit 0: 1 = leading-edge dead time, 0 = trailing. Bit 1: 1 = flag on both edges |
| a_wr | input | 1 | Write strobe for the duty shadow |
| a_data | input | W | Duty value to buffer |
| b_wr | input | 1 | Write strobe for the dead-time shadow |
| b_data | input | W | Dead-time value to buffer, in clock cycles |
| pwm_o | output | 1 | Registered PWM output |
| flag_o | output | 1 | Registered one-cycle edge flag |

## Verification
An undelayed edge shows on `pwm_o` one edge after the cycle that presents the crossing. A delayed edge shows D edges later, and `flag_o` moves on the same edge as the output change it marks. New shadow values take effect only in the period after the next zero of the time base. The bench therefore sets each configuration, lets one full period settle, and then compares every cycle of the following period. The expected values come from closed-form pulse bounds: the output is high from cycle A+1 to 2P−A+D in trailing mode, and from A+D+1 to 2P−A in leading mode. Inputs change on the falling clock edge, and outputs are read on the falling edge just before the next cycle's inputs are applied.

// File: rtl/cpwm_dt_pkg.sv
package cpwm_dt_pkg;
  typedef enum logic {
    DT_TRAIL = 1'b0,
    DT_LEAD  = 1'b1
  } dt_edge_e;

  typedef enum logic {
    FLG_FALL = 1'b0,
    FLG_BOTH = 1'b1
  } flag_sel_e;

  typedef struct packed {
    flag_sel_e flag_sel;
    dt_edge_e  dt_edge;
  } mode_t;

  localparam int NUM_LANES = 2;
  localparam int LANE_DUTY = 0;
  localparam int LANE_DEAD = 1;
endpackage

// File: rtl/cpwm_dt_buf.sv
module cpwm_dt_buf #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] din,
  input  logic         load,
  output logic [W-1:0] act
);
  logic [W-1:0] shadow_q;
  logic [W-1:0] act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      act_q    <= '0;
    end else begin
      if (wr) shadow_q <= din;
      if (load) act_q <= shadow_q;
    end
  end

  assign act = act_q;
endmodule

// File: rtl/cpwm_dt_cmp.sv
module cpwm_dt_cmp #(
  parameter int W = 16
) (
  input  logic [W-1:0] tb_val,
  input  logic         tb_up,
  input  logic [W-1:0] thr,
  output logic         hit_up,
  output logic         hit_dn
);
  logic eq;

  always_comb begin
    eq     = (tb_val == thr);
    hit_up = eq && tb_up;
    hit_dn = eq && !tb_up;
  end
endmodule

// File: rtl/cpwm_dt_timer.sv
module cpwm_dt_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         abort,
  input  logic [W-1:0] limit,
  output logic         fire
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic         run_q;
  logic [W-1:0] cnt_q;
  logic         zero_len;
  logic         reached;

  always_comb begin
    zero_len = (limit == '0);
    reached  = run_q && (cnt_q >= limit);
    fire     = (start && zero_len) || (!start && reached);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (abort) begin
      run_q <= 1'b0;
    end else if (start) begin
      run_q <= !zero_len;
      cnt_q <= ONE;
    end else if (run_q) begin
      if (reached) run_q <= 1'b0;
      else cnt_q <= cnt_q + ONE;
    end
  end
endmodule

// File: rtl/ctr_pwm_dt.sv
module ctr_pwm_dt
  import cpwm_dt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] tbase_val,
  input  logic         tbase_up,
  input  logic [1:0]   mode_sel,
  input  logic         a_wr,
  input  logic [W-1:0] a_data,
  input  logic         b_wr,
  input  logic [W-1:0] b_data,
  output logic         pwm_o,
  output logic         flag_o
);
  mode_t        mode;
  logic         at_min;
  logic         lane_wr  [NUM_LANES];
  logic [W-1:0] lane_din [NUM_LANES];
  logic [W-1:0] lane_act [NUM_LANES];

  assign mode   = mode_t'(mode_sel);
  assign at_min = (tbase_val == '0);

  assign lane_wr[LANE_DUTY]  = a_wr;
  assign lane_din[LANE_DUTY] = a_data;
  assign lane_wr[LANE_DEAD]  = b_wr;
  assign lane_din[LANE_DEAD] = b_data;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    cpwm_dt_buf #(.W(W)) u_buf (
      .clk  (clk),
      .rst  (rst),
      .wr   (lane_wr[i]),
      .din  (lane_din[i]),
      .load (at_min),
      .act  (lane_act[i])
    );
  end

  logic hit_up;
  logic hit_dn;

  cpwm_dt_cmp #(.W(W)) u_cmp (
    .tb_val (tbase_val),
    .tb_up  (tbase_up),
    .thr    (lane_act[LANE_DUTY]),
    .hit_up (hit_up),
    .hit_dn (hit_dn)
  );

  logic dt_start;
  logic direct_hit;
  logic direct_lvl;
  logic delayed_lvl;
  logic dt_fire;

  always_comb begin
    if (mode.dt_edge == DT_LEAD) begin
      dt_start    = hit_up;
      direct_hit  = hit_dn;
      direct_lvl  = 1'b0;
      delayed_lvl = 1'b1;
    end else begin
      dt_start    = hit_dn;
      direct_hit  = hit_up;
      direct_lvl  = 1'b1;
      delayed_lvl = 1'b0;
    end
  end

  cpwm_dt_timer #(.W(W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (dt_start),
    .abort (direct_hit),
    .limit (lane_act[LANE_DEAD]),
    .fire  (dt_fire)
  );

  logic out_q;
  logic flg_q;
  logic out_d;
  logic flg_d;

  always_comb begin
    out_d = out_q;
    if (direct_hit) out_d = direct_lvl;
    else if (dt_fire) out_d = delayed_lvl;
    flg_d = (out_q && !out_d) ||
            ((mode.flag_sel == FLG_BOTH) && !out_q && out_d);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= 1'b0;
      flg_q <= 1'b0;
    end else begin
      out_q <= out_d;
      flg_q <= flg_d;
    end
  end

  assign pwm_o  = out_q;
  assign flag_o = flg_q;
endmodule

// File: rtl/ctr_pwm_dt_chk.sv
module ctr_pwm_dt_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] tbase_val,
  input logic         tbase_up,
  input logic [1:0]   mode_sel,
  input logic         pwm_o,
  input logic         flag_o,
  input logic [W-1:0] a_act,
  input logic [W-1:0] b_act
);
  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(tbase_val == '0)) |-> ($stable(a_act) && $stable(b_act)));  // R2

  AST_TRAIL_RISE: assert property (@(posedge clk) disable iff (rst)
    (!mode_sel[0] && tbase_up && tbase_val == a_act) |=> pwm_o);  // R3

  AST_LEAD_ZERO_GAP: assert property (@(posedge clk) disable iff (rst)
    (mode_sel[0] && tbase_up && tbase_val == a_act && b_act == '0) |=> pwm_o);  // R5

  AST_LEAD_FALL: assert property (@(posedge clk) disable iff (rst)
    (mode_sel[0] && !tbase_up && tbase_val == a_act) |=> !pwm_o);  // R6

  AST_FLAG_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(pwm_o) |-> flag_o);  // R8

  AST_FLAG_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
    flag_o |-> (pwm_o != $past(pwm_o)));  // R8

  AST_FLAG_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm_o) |-> (flag_o == $past(mode_sel[1])));  // R9
endmodule

bind ctr_pwm_dt ctr_pwm_dt_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tbase_val (tbase_val),
  .tbase_up  (tbase_up),
  .mode_sel  (mode_sel),
  .pwm_o     (pwm_o),
  .flag_o    (flag_o),
  .a_act     (lane_act[0]),
  .b_act     (lane_act[1])
);

// File: tb/ctr_pwm_dt_test.sv
module ctr_pwm_dt_test;
  localparam int W = 4;
  localparam int P = 7;
  localparam int L = 2 * P;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] tbase_val;
  logic         tbase_up;
  logic [1:0]   mode_sel;
  logic         a_wr;
  logic [W-1:0] a_data;
  logic         b_wr;
  logic [W-1:0] b_data;
  logic         pwm_o;
  logic         flag_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  ctr_pwm_dt #(.W(W)) uut (
    .clk       (clk),
    .rst       (rst),
    .tbase_val (tbase_val),
    .tbase_up  (tbase_up),
    .mode_sel  (mode_sel),
    .a_wr      (a_wr),
    .a_data    (a_data),
    .b_wr      (b_wr),
    .b_data    (b_data),
    .pwm_o     (pwm_o),
    .flag_o    (flag_o)
  );

  function automatic bit exp_out(int m, int a, int d, int t);
    if (m % 2 == 0) return (t >= a + 1) && (t <= L - a + d);
    return (t >= a + d + 1) && (t <= L - a);
  endfunction

  function automatic bit exp_flag(int m, int a, int d, int t);
    bit prev;
    bit cur;
    prev = exp_out(m, a, d, (t + L - 1) % L);
    cur  = exp_out(m, a, d, t);
    return (prev && !cur) || ((m >= 2) && !prev && cur);
  endfunction

  task automatic check_bit(input logic act, input bit expv, input string req,
                           input int m, input int a, input int d, input int t);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s mode=%0d duty=%0d dead=%0d t=%0d actual=%b expected=%b",
               req, m, a, d, t, act, expv);
    end
  endtask

  task automatic run_period(input bit chk, input int m, input int a,
                            input int d, input bit wr);
    for (int t = 0; t < L; t++) begin
      @(negedge clk);
      if (chk) begin
        check_bit(pwm_o, exp_out(m, a, d, t),
                  (m % 2 == 0) ? "R2 R3 R4 pwm" : "R2 R5 R6 R7 pwm", m, a, d, t);
        check_bit(flag_o, exp_flag(m, a, d, t),
                  (m >= 2) ? "R8 R9 flag" : "R8 flag", m, a, d, t);
      end
      tbase_val = W'((t <= P) ? t : L - t);
      tbase_up  = (t < P);
      mode_sel  = 2'(m);
      a_wr      = wr && (t == 1);
      b_wr      = wr && (t == 1);
      a_data    = W'(a);
      b_data    = W'(d);
    end
  endtask

  initial begin
    rst       = 1'b1;
    tbase_val = W'(P);
    tbase_up  = 1'b0;
    mode_sel  = 2'b00;
    a_wr      = 1'b0;
    b_wr      = 1'b0;
    a_data    = '0;
    b_data    = '0;
    repeat (3) @(negedge clk);
    check_bit(pwm_o, 1'b0, "R1 reset pwm", 0, 0, 0, 0);
    check_bit(flag_o, 1'b0, "R1 reset flag", 0, 0, 0, 0);
    rst = 1'b0;
    @(negedge clk);
    check_bit(pwm_o, 1'b0, "R1 after reset pwm", 0, 0, 0, 0);
    check_bit(flag_o, 1'b0, "R1 after reset flag", 0, 0, 0, 0);

    for (int m = 0; m < 4; m++) begin
      for (int a = 1; a < P; a++) begin
        int dmax;
        dmax = (m % 2 == 0) ? a - 1 : L - 2 * a + 1;
        for (int d = 0; d <= dmax; d++) begin
          run_period(1'b0, m, a, d, 1'b1);
          run_period(1'b0, m, a, d, 1'b0);
          run_period(1'b1, m, a, d, 1'b0);
        end
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule